// File: doc/BRIEF.md
# PLL Control and Status Register Bank

This block is the byte-wide register bank that software uses to program and monitor a clock generator built around a PLL. It sits on a simple 8-bit peripheral bus: an address, write data, a write strobe, a read strobe and combinational read data. Six byte registers in a window of consecutive addresses hold the PLL enable, the base clock source select, the lock interrupt enable, the loop bandwidth mode bits, a 12-bit feedback multiplier, an 8-bit VCO range and a 2-bit VCO power-of-two prescale. Every field also drives a port toward the analog PLL.

The registers are not independent. The loop's mode bits decide whether the interrupt enable, the lock status and the acquisition bit can be written or seen. The PLL enable and the VCO range decide whether the base clock can be switched onto the VCO. While the PLL is running, its frequency programming is frozen. A lock indication from an external detector is resynchronised, and each change of it raises a sticky flag. A read of the control register clears that flag, and the flag drives an interrupt request.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the six registers read, in window order (offset 0 to 5), 0x20, 0x00, 0x00, 0x40, 0x40, 0x01. The PLL enable is 1, the multiplier is 0x040 and the VCO range is 0x40.
- R2: The window starts at BASE_ADDR (default 0x36), in this order: control, bandwidth, multiplier high, multiplier low, VCO range, reserved. Addresses outside it read 0x00. Control bits 3:2, bandwidth bits 4:0, the multiplier-high upper nibble and the reserved register ignore writes. Each of these bits reads as 0, except reserved-register bit 0, which reads 1.
- R3: While auto mode (bandwidth bit 7) is 0, the interrupt enable (control bit 7) is held at 0 and ignores writes. Under the same condition the lock flag (control bit 6) and the lock status (bandwidth bit 6) read as 0, and irq stays low.
- R4: While auto mode is 1, the acquisition bit (bandwidth bit 5) ignores writes. While auto mode is 0, it is writable.
- R5: Clock select (control bit 4) can be set only if the PLL enable that results from the same write is 1 and the VCO range is not 0x00. In every other case it reads 0.
- R6: While clock select is 1, the PLL enable (control bit 5) stays at 1 and ignores writes.
- R7: While the PLL enable is 1, writes to the multiplier high, multiplier low and VCO range registers are ignored.
- R8: In auto mode, each change of the synchronised lock status sets the lock flag. A read of the control register (read strobe at that address) clears it. If a change and the clearing read fall in the same cycle, the flag is set.
- R9: irq is 1 exactly when the lock flag and the interrupt enable are both 1.
- R10: The lock status bit follows lock_in after SYNC_STAGES clock edges. Changes of lock_in that happen while auto mode is 0 never set the flag.
- R11: The prescale field (control bits 1:0) is writable in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| rd_en | input | 1 | Read strobe; only side effect is clearing the lock flag |
| rdata | output | 8 | Combinational read data for addr |
| lock_in | input | 1 | Lock indication from the external detector |
| irq | output | 1 | Lock interrupt request |
| pll_on | output | 1 | PLL enable |
| clk_sel | output | 1 | Base clock taken from the VCO when 1 |
| auto_mode | output | 1 | Automatic bandwidth mode |
| acq_mode | output | 1 | Acquisition (wide bandwidth) mode |
| vco_prescale | output | 2 | VCO power-of-two prescale |
| mult | output | MUL_W | Feedback multiplier |
| vco_range | output | 8 | VCO range |

## Verification
The bench builds the block with its defaults: a 0x36 window in an 8-bit address space, a 12-bit multiplier and a two-stage lock synchroniser. Random addresses span 0x30 to 0x3F, so reads and writes land on both sides of the window. The four-bit multiplier-high field lets unimplemented bits be written with ones. The two-stage synchroniser makes the lock latency visible edge by edge. It also allows a read of the control register to be placed in the same cycle as a detected lock change.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

   localparam int unsigned DATA_W   = 8;
   localparam int unsigned NUM_REGS = 6;

   // register slots, in window order
   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_BW    = 3'd1,
      SEL_MULH  = 3'd2,
      SEL_MULL  = 3'd3,
      SEL_RANGE = 3'd4,
      SEL_RSVD  = 3'd5,
      SEL_NONE  = 3'd7
   } reg_sel_e;

   // control register bit positions
   localparam int unsigned CTL_IE   = 7;
   localparam int unsigned CTL_FLAG = 6;
   localparam int unsigned CTL_ON   = 5;
   localparam int unsigned CTL_SEL  = 4;
   localparam int unsigned CTL_VPR  = 0;
   localparam int unsigned VPR_W    = 2;

   // bandwidth register bit positions
   localparam int unsigned BW_AUTO = 7;
   localparam int unsigned BW_LOCK = 6;
   localparam int unsigned BW_ACQ  = 5;

   localparam logic [DATA_W-1:0] CTRL_RST = 8'h20;
   localparam logic [DATA_W-1:0] BW_RST   = 8'h00;
   localparam logic [DATA_W-1:0] RSVD_VAL = 8'h01;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else if (STAGES == 1) begin
               chain_q <= d;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d};
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pll_lock_flag.sv
module pll_lock_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_s,
   input  logic arm,
   input  logic clr,
   input  logic ie,
   output logic flag,
   output logic irq
);

   logic prev_q;
   logic flag_q;
   logic flag_nxt;
   logic change;

   assign change = lock_s ^ prev_q;

   always_comb begin
      flag_nxt = 1'b0;
      if (arm) begin
         // a detected change beats a clearing read in the same cycle
         flag_nxt = (flag_q & ~clr) | change;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= lock_s;
         flag_q <= flag_nxt;
      end
   end

   assign flag = flag_q & arm;
   assign irq  = flag & ie;

endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs #(
   parameter int unsigned MUL_W     = 12,
   parameter int unsigned MUL_RST   = 'h040,
   parameter int unsigned RANGE_RST = 'h40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frozen,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic             wr_rng,
   input  logic [7:0]       wdata,
   output logic [MUL_W-1:0] mult,
   output logic [7:0]       vco_range,
   output logic [7:0]       rd_hi,
   output logic [7:0]       rd_lo
);

   localparam int unsigned HI_W = MUL_W - 8;
   localparam logic [MUL_W-1:0] MUL_INIT = MUL_W'(MUL_RST);
   localparam logic [7:0]       RNG_INIT = 8'(RANGE_RST);

   logic [HI_W-1:0] hi_q;
   logic [7:0]      lo_q;
   logic [7:0]      rng_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= MUL_INIT[MUL_W-1:8];
         lo_q  <= MUL_INIT[7:0];
         rng_q <= RNG_INIT;
      end else if (!frozen) begin
         if (wr_hi) begin
            hi_q <= wdata[HI_W-1:0];
         end
         if (wr_lo) begin
            lo_q <= wdata;
         end
         if (wr_rng) begin
            rng_q <= wdata;
         end
      end
   end

   assign mult      = {hi_q, lo_q};
   assign vco_range = rng_q;
   assign rd_lo     = lo_q;

   generate
      if (HI_W == 8) begin : g_full_hi
         assign rd_hi = hi_q;
      end else begin : g_part_hi
         assign rd_hi = {{(8 - HI_W){1'b0}}, hi_q};
      end
   endgenerate

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
   import pll_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BASE_ADDR   = 'h36,
   parameter int unsigned MUL_W       = 12,
   parameter int unsigned MUL_RST     = 'h040,
   parameter int unsigned RANGE_RST   = 'h40,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [7:0]        rdata,
   input  logic              lock_in,
   output logic              irq,
   output logic              pll_on,
   output logic              clk_sel,
   output logic              auto_mode,
   output logic              acq_mode,
   output logic [1:0]        vco_prescale,
   output logic [MUL_W-1:0]  mult,
   output logic [7:0]        vco_range
);

   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   // elaboration-time parameter checks
   generate
      if (MUL_W < 9 || MUL_W > 16) begin : g_bad_mul_w
         $error("MUL_W must lie in 9..16");
      end
      if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ADDR_W must lie in 3..16");
      end
      if (BASE_ADDR + NUM_REGS > (1 << ADDR_W)) begin : g_bad_base
         $error("register window does not fit the address space");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (RANGE_RST > 255 || MUL_RST >= (1 << MUL_W)) begin : g_bad_rst
         $error("reset value wider than its field");
      end
   endgenerate

   // address decode
   logic [ADDR_W-1:0] off;
   reg_sel_e          sel;

   assign off = addr - BASE;

   always_comb begin
      if (off < ADDR_W'(NUM_REGS)) begin
         sel = reg_sel_e'(off[2:0]);
      end else begin
         sel = SEL_NONE;
      end
   end

   logic wr_ctrl, wr_bw, rd_ctrl;
   assign wr_ctrl = wr_en && (sel == SEL_CTRL);
   assign wr_bw   = wr_en && (sel == SEL_BW);
   assign rd_ctrl = rd_en && (sel == SEL_CTRL);

   // control and bandwidth state
   logic             ie_q, on_q, csel_q, auto_q, acq_q;
   logic [VPR_W-1:0] vpr_q;
   logic             ie_nxt, on_nxt, csel_nxt, auto_nxt, acq_nxt;
   logic [VPR_W-1:0] vpr_nxt;
   logic             range_ok;

   always_comb begin
      on_nxt   = on_q;
      ie_nxt   = ie_q & auto_q;
      csel_nxt = csel_q & on_q & range_ok;
      vpr_nxt  = vpr_q;
      auto_nxt = auto_q;
      acq_nxt  = acq_q;
      if (wr_ctrl) begin
         on_nxt   = csel_q | wdata[CTL_ON];
         ie_nxt   = auto_q & wdata[CTL_IE];
         csel_nxt = wdata[CTL_SEL] & on_nxt & range_ok;
         vpr_nxt  = wdata[CTL_VPR +: VPR_W];
      end
      if (wr_bw) begin
         auto_nxt = wdata[BW_AUTO];
         if (!auto_q) begin
            acq_nxt = wdata[BW_ACQ];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= CTRL_RST[CTL_IE];
         on_q   <= CTRL_RST[CTL_ON];
         csel_q <= CTRL_RST[CTL_SEL];
         vpr_q  <= CTRL_RST[CTL_VPR +: VPR_W];
         auto_q <= BW_RST[BW_AUTO];
         acq_q  <= BW_RST[BW_ACQ];
      end else begin
         ie_q   <= ie_nxt;
         on_q   <= on_nxt;
         csel_q <= csel_nxt;
         vpr_q  <= vpr_nxt;
         auto_q <= auto_nxt;
         acq_q  <= acq_nxt;
      end
   end

   // frequency programming
   logic [7:0] rd_hi, rd_lo;

   pll_prog_regs #(
      .MUL_W     (MUL_W),
      .MUL_RST   (MUL_RST),
      .RANGE_RST (RANGE_RST)
   ) u_prog (
      .clk       (clk),
      .rst_n     (rst_n),
      .frozen    (on_q),
      .wr_hi     (wr_en && (sel == SEL_MULH)),
      .wr_lo     (wr_en && (sel == SEL_MULL)),
      .wr_rng    (wr_en && (sel == SEL_RANGE)),
      .wdata     (wdata),
      .mult      (mult),
      .vco_range (vco_range),
      .rd_hi     (rd_hi),
      .rd_lo     (rd_lo)
   );

   assign range_ok = |vco_range;

   // lock status path
   logic lock_s, flag;

   pll_lock_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lock_in),
      .q     (lock_s)
   );

   pll_lock_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .lock_s (lock_s),
      .arm    (auto_q),
      .clr    (rd_ctrl),
      .ie     (ie_q),
      .flag   (flag),
      .irq    (irq)
   );

   // read mux
   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            rdata[CTL_IE]              = ie_q & auto_q;
            rdata[CTL_FLAG]            = flag;
            rdata[CTL_ON]              = on_q;
            rdata[CTL_SEL]             = csel_q;
            rdata[CTL_VPR +: VPR_W]    = vpr_q;
         end
         SEL_BW: begin
            rdata[BW_AUTO] = auto_q;
            rdata[BW_LOCK] = lock_s & auto_q;
            rdata[BW_ACQ]  = acq_q;
         end
         SEL_MULH:  rdata = rd_hi;
         SEL_MULL:  rdata = rd_lo;
         SEL_RANGE: rdata = vco_range;
         SEL_RSVD:  rdata = RSVD_VAL;
         default:   rdata = '0;
      endcase
   end

   assign pll_on       = on_q;
   assign clk_sel      = csel_q;
   assign auto_mode    = auto_q;
   assign acq_mode     = acq_q;
   assign vco_prescale = vpr_q;

endmodule

// File: rtl/pll_ctl_regs_chk.sv
module pll_ctl_regs_chk #(
   parameter int unsigned MUL_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pll_on,
   input logic             clk_sel,
   input logic             auto_mode,
   input logic             acq_mode,
   input logic             irq,
   input logic [MUL_W-1:0] mult,
   input logic [7:0]       vco_range
);

   // R6
   sel_holds_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel |-> pll_on);

   // R5
   sel_needs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel |-> (vco_range != 8'h00));

   // R7
   prog_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_on |=> ($stable(mult) && $stable(vco_range)));

   // R4
   acq_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode |=> $stable(acq_mode));

   // R3
   irq_needs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> auto_mode);

   // R6
   on_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel |=> pll_on);

endmodule

bind pll_ctl_regs pll_ctl_regs_chk #(.MUL_W(MUL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pll_on    (pll_on),
   .clk_sel   (clk_sel),
   .auto_mode (auto_mode),
   .acq_mode  (acq_mode),
   .irq       (irq),
   .mult      (mult),
   .vco_range (vco_range)
);

// File: tb/pll_ctl_regs_tb_top.sv
module pll_ctl_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;
   logic        lock_in = 1'b0;
   logic        irq, pll_on, clk_sel, auto_mode, acq_mode;
   logic [1:0]  vco_prescale;
   logic [11:0] mult;
   logic [7:0]  vco_range;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;

   always #2 clk = ~clk;

   pll_ctl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .lock_in(lock_in), .irq(irq),
      .pll_on(pll_on), .clk_sel(clk_sel), .auto_mode(auto_mode),
      .acq_mode(acq_mode), .vco_prescale(vco_prescale), .mult(mult),
      .vco_range(vco_range)
   );

   // reference model state
   logic        m_ie = 0, m_flag = 0, m_on = 1, m_sel = 0;
   logic        m_auto = 0, m_acq = 0, m_lock = 0;
   logic [1:0]  m_vpr = 0;
   logic [11:0] m_mul = 12'h040;
   logic [7:0]  m_rng = 8'h40;

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      case (a)
         8'h36: return {m_ie & m_auto, m_flag & m_auto, m_on, m_sel, 2'b00, m_vpr};
         8'h37: return {m_auto, m_lock & m_auto, m_acq, 5'b0};
         8'h38: return {4'b0, m_mul[11:8]};
         8'h39: return m_mul[7:0];
         8'h3A: return m_rng;
         8'h3B: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [26:0] exp_ports();
      return {m_on, m_sel, m_auto, m_acq, m_flag & m_ie & m_auto, m_vpr, m_mul, m_rng};
   endfunction

   task automatic model_write(logic [7:0] a, logic [7:0] d);
      logic on_new;
      case (a)
         8'h36: begin
            on_new = m_sel | d[5];
            m_ie   = m_auto & d[7];
            m_sel  = d[4] & on_new & (m_rng != 8'h00);
            m_on   = on_new;
            m_vpr  = d[1:0];
         end
         8'h37: begin
            if (!m_auto) m_acq = d[5];
            m_auto = d[7];
            if (!m_auto) begin
               m_ie   = 1'b0;
               m_flag = 1'b0;
            end
         end
         8'h38: if (!m_on) m_mul[11:8] = d[3:0];
         8'h39: if (!m_on) m_mul[7:0] = d;
         8'h3A: if (!m_on) m_rng = d;
         default: ;
      endcase
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_ports(string tag);
      check(tag, 32'({pll_on, clk_sel, auto_mode, acq_mode, irq, vco_prescale, mult, vco_range}),
            32'(exp_ports()));
   endtask

   task automatic do_write(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic do_read(logic [7:0] a, string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 check(tag, 32'(rdata), 32'(exp_rd(a)));
      @(negedge clk);
      rd_en = 1'b0;
      if (a == 8'h36) m_flag = 1'b0;
   endtask

   task automatic read_fixed(logic [7:0] a, logic [7:0] e, string tag);
      @(negedge clk);
      addr = a;
      #1 check(tag, 32'(rdata), 32'(e));
   endtask

   task automatic set_lock(logic v);
      @(negedge clk);
      lock_in = v;
      repeat (4) @(negedge clk);
      m_lock = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      read_fixed(8'h36, 8'h20, "R1 ctrl");
      read_fixed(8'h37, 8'h00, "R1 bw");
      read_fixed(8'h38, 8'h00, "R1 mulh");
      read_fixed(8'h39, 8'h40, "R1 mull");
      read_fixed(8'h3A, 8'h40, "R1 range");
      read_fixed(8'h3B, 8'h01, "R1 rsvd");
      #1 check_ports("R1 ports");

      // R2 reserved / unimplemented / outside window
      do_write(8'h3B, 8'hFF); do_read(8'h3B, "R2 rsvd");
      do_write(8'h36, 8'h0C); do_read(8'h36, "R2 ctrl reserved bits");
      do_write(8'h37, 8'h1F); do_read(8'h37, "R2 bw low bits");
      do_read(8'h35, "R2 below window");
      do_read(8'h3C, "R2 above window");

      // R7 programming while PLL off, then R2 high nibble
      do_write(8'h38, 8'hFA); do_read(8'h38, "R2 mulh upper nibble");
      do_write(8'h39, 8'h5C); do_read(8'h39, "R7 mull written while off");
      do_write(8'h3A, 8'h00); do_read(8'h3A, "R7 range written while off");

      // R5 clock select gating
      do_write(8'h36, 8'h30); do_read(8'h36, "R5 range zero blocks select");
      do_write(8'h36, 8'h00);
      do_write(8'h3A, 8'h81);
      do_write(8'h36, 8'h10); do_read(8'h36, "R5 pll off blocks select");
      do_write(8'h36, 8'h30); do_read(8'h36, "R5 select with enable");
      #1 check_ports("R5 ports");

      // R6 enable held, R7 frozen programming
      do_write(8'h36, 8'h00); do_read(8'h36, "R6 enable held");
      do_write(8'h36, 8'h30);
      do_write(8'h39, 8'h11); do_read(8'h39, "R7 mull frozen");
      do_write(8'h3A, 8'h00); do_read(8'h3A, "R7 range frozen");
      do_write(8'h38, 8'h03); do_read(8'h38, "R7 mulh frozen");

      // R11 prescale always writable
      do_write(8'h36, 8'h33); do_read(8'h36, "R11 prescale");
      do_write(8'h36, 8'h22); do_read(8'h36, "R11 prescale clear select");
      do_write(8'h36, 8'h00); do_read(8'h36, "R11 enable off");

      // R4 acquisition bit
      do_write(8'h37, 8'h20); do_read(8'h37, "R4 acq writable manual");
      do_write(8'h37, 8'hA0); do_read(8'h37, "R4 enter auto");
      do_write(8'h37, 8'h80); do_read(8'h37, "R4 acq locked in auto");
      do_write(8'h37, 8'h00); do_read(8'h37, "R4 acq writable again");

      // R3 interrupt enable held in manual mode
      do_write(8'h36, 8'h80); do_read(8'h36, "R3 ie held");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0] a, d;
         a = 8'h30 + 8'($urandom % 16);
         d = 8'($urandom);
         if ($urandom % 2) do_write(a, d);
         else do_read(a, "R2 random read");
         #1 check_ports("R7 random ports");
      end

      // lock path: R10 latency, R8 flag, R9 irq
      do_write(8'h36, 8'h00);
      do_write(8'h37, 8'h80);
      do_write(8'h36, 8'h80); do_read(8'h36, "R3 ie writable in auto");
      @(negedge clk); addr = 8'h37; lock_in = 1'b1;
      @(negedge clk); #1 check("R10 lock after one edge", 32'(rdata), 32'h80);
      @(negedge clk); #1 check("R10 lock after two edges", 32'(rdata), 32'hC0);
      repeat (2) @(negedge clk);
      m_lock = 1'b1; m_flag = 1'b1;
      #1 check_ports("R9 irq raised");
      do_read(8'h36, "R8 flag set on rise");
      #1 check_ports("R8 irq cleared by read");
      do_read(8'h36, "R8 flag cleared");

      set_lock(1'b0); m_flag = 1'b1;
      do_write(8'h36, 8'h00);
      #1 check_ports("R9 no irq without enable");
      do_read(8'h36, "R8 flag set on fall");

      // R8 set wins over clearing read in the same cycle
      @(negedge clk); addr = 8'h36; lock_in = 1'b1;
      @(negedge clk);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      m_lock = 1'b1; m_flag = 1'b1;
      do_read(8'h36, "R8 set wins over clear");

      // R3 / R10 manual mode masks lock and flag
      do_write(8'h37, 8'h00);
      set_lock(1'b0);
      do_read(8'h36, "R3 flag masked");
      do_read(8'h37, "R3 lock masked");
      do_write(8'h37, 8'h80);
      do_read(8'h36, "R10 no flag from manual-mode change");
      set_lock(1'b1); m_flag = 1'b1;
      do_read(8'h37, "R10 lock visible in auto");
      #1 check_ports("R9 final ports");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule